// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Load/Store Processor

A small load/store processor. Every instruction fills one 16-bit word, and every datum is a 16-bit two's-complement integer. Instructions and data live in one external word-addressed memory of up to 64K words. The core reaches that memory through an address bus, one bidirectional data bus, and read and write strobes. The core holds a program counter, an instruction register, a three-read/one-write register array, an add/subtract ALU with signed compare flags, immediate sign extension and a tristate bus driver. A finite-state sequencer steps each instruction through fetch, decode, execute, an optional memory step and write-back.

The instruction set has ten of the sixteen possible opcodes. It covers add/subtract expressions, base-plus-index array access, a compare that sets flags, branches on all six signed relations, and subroutine call and return. Parameters pass either as a value in a register or as an address that the callee dereferences. The surrounding system supplies the memory and holds the core in synchronous reset until the program image is in place.

Top module: `cpu16_core`

## Requirements
- R1: While reset is high at a rising edge, the core is put in the fetch step with PC = 0. In the first cycle after reset it drives address 0 with the read strobe high and the write strobe low.
- R2: A fetch drives the PC onto the address bus with the read strobe high, and PC then steps by one. Fetches of consecutive instructions are 4 cycles apart, or 5 cycles apart after a load or store.
- R3: Opcode 0 (add) and opcode 1 (subtract) compute reg[bits 11:8] = reg[bits 7:4] +/- reg[bits 3:0], wrapping modulo 2^16.
- R4: Opcode 2 loads reg[11:8] with the sign-extended 8-bit immediate in bits 7:0. Opcode 3 adds that sign-extended immediate to reg[11:8].
- R5: Opcode 4 (load) reads memory at reg[7:4]+reg[3:0] into reg[11:8]. Opcode 5 (store) writes reg[11:8] to that address. The memory access happens in the fourth cycle of the instruction.
- R6: Opcode 6 compares reg[7:4] with reg[3:0] as signed values. Opcode 7 branches to PC+1+sext(bits 7:0) when the condition in bits 10:8 holds: 0 equal, 1 not equal, 2 greater, 3 less-or-equal, 4 less, 5 greater-or-equal, 6 always, 7 never. Only opcode 6 changes the flags.
- R7: Opcode 8 (call) writes the return address PC+1 into reg[11:8] and jumps to PC+1+sext(bits 7:0). Opcode 9 (return) jumps to the address held in reg[7:4].
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: Opcodes 10 to 15 change no register, no memory word and no flag. They only advance the PC.
- R10: The read and write strobes are never high together. The write strobe lasts exactly one cycle per store, and the core drives the data bus only during that cycle, with the value being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_o | output | 16 | Word address to memory |
| data_io | inout | 16 | Shared data bus, driven by the core only while writing |
| mem_rd_o | output | 1 | Memory read strobe (fetch or load) |
| mem_we_o | output | 1 | Memory write strobe (store) |

## Verification
The bus is due at fixed offsets from the release of reset. Instruction k's fetch address appears on the bus 4 cycles after fetch k-1, or 5 cycles after it when k-1 was a load or store. A store's strobe and data appear in that instruction's fourth cycle. The bench records the bus half a cycle after each edge for forty cycles and compares it against these computed offsets. Arithmetic, compare and call results are not visible until a later store moves them to memory. Each program therefore ends in a self-loop, runs for a fixed number of cycles well beyond its worst-case length, and only then has its memory words compared.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_LDI  = 4'd2,
      OP_ADDI = 4'd3,
      OP_LD   = 4'd4,
      OP_ST   = 4'd5,
      OP_CMP  = 4'd6,
      OP_BR   = 4'd7,
      OP_CALL = 4'd8,
      OP_JR   = 4'd9
   } opc_e;

   typedef enum logic [2:0] {
      S_FETCH  = 3'd0,
      S_DECODE = 3'd1,
      S_EXEC   = 3'd2,
      S_MEM    = 3'd3,
      S_WB     = 3'd4
   } step_e;

   typedef struct packed {
      logic z;
      logic n;
      logic v;
   } flags_t;

   function automatic logic cond_met(input logic [2:0] cond, input flags_t f);
      logic lt;
      lt = f.n ^ f.v;
      case (cond)
         3'd0:    cond_met = f.z;
         3'd1:    cond_met = !f.z;
         3'd2:    cond_met = !f.z && !lt;
         3'd3:    cond_met = f.z || lt;
         3'd4:    cond_met = lt;
         3'd5:    cond_met = !lt;
         3'd6:    cond_met = 1'b1;
         default: cond_met = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu #(
   parameter int W = 16
) (
   input  logic [W-1:0]      x_i,
   input  logic [W-1:0]      y_i,
   input  logic              sub_i,
   output logic [W-1:0]      sum_o,
   output cpu16_pkg::flags_t flg_o
);
   logic [W-1:0] y_eff;

   always_comb begin
      y_eff   = sub_i ? ~y_i : y_i;
      sum_o   = x_i + y_eff + {{(W-1){1'b0}}, sub_i};
      flg_o.z = (sum_o == '0);
      flg_o.n = sum_o[W-1];
      flg_o.v = (x_i[W-1] == y_eff[W-1]) && (sum_o[W-1] != x_i[W-1]);
   end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
   parameter int W        = 16,
   parameter int NREG     = 16,
   parameter int RD_PORTS = 3,
   parameter bit ZERO_R0  = 1'b1,
   localparam int AW      = $clog2(NREG)
) (
   input  logic          clk_i,
   input  logic [AW-1:0] ra_i [RD_PORTS],
   output logic [W-1:0]  rd_o [RD_PORTS],
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [W-1:0]  wd_i
);
   logic [W-1:0] arr_q [NREG];

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("register count must be a power of two >= 2");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (ZERO_R0 && r == 0) begin : g_zero
         always_ff @(posedge clk_i) arr_q[r] <= '0;
      end else begin : g_store
         always_ff @(posedge clk_i)
            if (we_i && wa_i == AW'(r)) arr_q[r] <= wd_i;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_o[p] = arr_q[ra_i[p]];
   end

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
   import cpu16_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_i,
   input  logic [3:0] op_i,
   output step_e step_o,
   output logic  mem_rd_o,
   output logic  mem_we_o,
   output logic  rf_we_o,
   output logic  wb_mdr_o
);
   step_e st_q, st_d;
   logic  is_mem, writes_reg;

   always_comb begin
      is_mem     = (op_i == OP_LD) || (op_i == OP_ST);
      writes_reg = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_LDI) ||
                   (op_i == OP_ADDI) || (op_i == OP_LD) || (op_i == OP_CALL);
      case (st_q)
         S_FETCH:  st_d = S_DECODE;
         S_DECODE: st_d = S_EXEC;
         S_EXEC:   st_d = is_mem ? S_MEM : S_WB;
         S_MEM:    st_d = S_WB;
         default:  st_d = S_FETCH;
      endcase
   end

   always_ff @(posedge clk_i)
      if (rst_i) st_q <= S_FETCH;
      else       st_q <= st_d;

   assign step_o   = st_q;
   assign mem_rd_o = (st_q == S_FETCH) || (st_q == S_MEM && op_i == OP_LD);
   assign mem_we_o = (st_q == S_MEM) && (op_i == OP_ST);
   assign rf_we_o  = (st_q == S_WB) && writes_reg;
   assign wb_mdr_o = (op_i == OP_LD);

   // R1: reset puts the sequencer back at fetch
   a_r1_reset_fetch: assert property (@(posedge clk_i) rst_i |=> st_q == S_FETCH);
   // R9: undefined opcodes never write a register
   a_r9_undef_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == S_WB && op_i >= 4'd10) |-> !rf_we_o);
   // R2: the memory step follows execute only for load/store
   a_r2_mem_step: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == S_MEM) |-> $past(st_q) == S_EXEC);

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
   import cpu16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 16,
   parameter int NREG    = 16,
   parameter int IMM_W   = 8,
   parameter bit ZERO_R0 = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   output logic [ADDR_W-1:0] addr_o,
   inout  wire  [DATA_W-1:0] data_io,
   output logic              mem_rd_o,
   output logic              mem_we_o
);
   localparam int RAW = $clog2(NREG);

   if (DATA_W != 16) begin : g_bad_w
      $error("instruction encoding needs a 16-bit word");
   end
   if (ADDR_W > DATA_W) begin : g_bad_a
      $error("address must fit in a register");
   end
   if (IMM_W > 8 || IMM_W < 2) begin : g_bad_imm
      $error("immediate must fit in bits 7:0");
   end
   if (NREG > 16) begin : g_bad_nreg
      $error("register fields are 4 bits");
   end

   logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, c_q, res_q, mdr_q;
   flags_t            flg_q, alu_flg;
   step_e             step;
   logic              rf_we, wb_mdr;
   logic [3:0]        op;
   logic [DATA_W-1:0] imm, alu_x, alu_y, alu_sum;
   logic              alu_sub;
   logic [RAW-1:0]    rf_ra [3];
   logic [DATA_W-1:0] rf_rd [3];

   assign op  = ir_q[15:12];
   assign imm = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

   assign rf_ra[0] = RAW'(ir_q[7:4]);
   assign rf_ra[1] = RAW'(ir_q[3:0]);
   assign rf_ra[2] = RAW'(ir_q[11:8]);

   cpu16_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .op_i     (op),
      .step_o   (step),
      .mem_rd_o (mem_rd_o),
      .mem_we_o (mem_we_o),
      .rf_we_o  (rf_we),
      .wb_mdr_o (wb_mdr)
   );

   cpu16_regfile #(
      .W(DATA_W), .NREG(NREG), .RD_PORTS(3), .ZERO_R0(ZERO_R0)
   ) u_rf (
      .clk_i (clk_i),
      .ra_i  (rf_ra),
      .rd_o  (rf_rd),
      .we_i  (rf_we),
      .wa_i  (RAW'(ir_q[11:8])),
      .wd_i  (wb_mdr ? mdr_q : res_q)
   );

   always_comb begin
      alu_x   = a_q;
      alu_y   = b_q;
      alu_sub = 1'b0;
      case (op)
         OP_SUB, OP_CMP: alu_sub = 1'b1;
         OP_LDI:         begin alu_x = '0;   alu_y = imm; end
         OP_ADDI:        begin alu_x = c_q;  alu_y = imm; end
         OP_BR, OP_CALL: begin alu_x = pc_q; alu_y = imm; end
         default: ;
      endcase
   end

   cpu16_alu #(.W(DATA_W)) u_alu (
      .x_i   (alu_x),
      .y_i   (alu_y),
      .sub_i (alu_sub),
      .sum_o (alu_sum),
      .flg_o (alu_flg)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pc_q  <= '0;
         ir_q  <= '0;
         flg_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
         c_q   <= '0;
         res_q <= '0;
         mdr_q <= '0;
      end else begin
         case (step)
            S_FETCH: begin
               ir_q <= data_io;
               pc_q <= pc_q + 1'b1;
            end
            S_DECODE: begin
               a_q <= rf_rd[0];
               b_q <= rf_rd[1];
               c_q <= rf_rd[2];
            end
            S_EXEC: begin
               res_q <= (op == OP_CALL) ? pc_q : alu_sum;
               if (op == OP_CMP) flg_q <= alu_flg;
               if ((op == OP_BR && cond_met(ir_q[10:8], flg_q)) || op == OP_CALL)
                  pc_q <= alu_sum;
               if (op == OP_JR) pc_q <= a_q;
            end
            S_MEM: if (op == OP_LD) mdr_q <= data_io;
            default: ;
         endcase
      end
   end

   assign addr_o  = (step == S_MEM) ? res_q[ADDR_W-1:0] : pc_q[ADDR_W-1:0];
   assign data_io = mem_we_o ? c_q : 'z;

   // R10: strobes exclusive
   a_r10_strobe_excl: assert property (@(posedge clk_i) disable iff (rst_i)
      !(mem_rd_o && mem_we_o));
   // R10: one write cycle per store
   a_r10_we_single: assert property (@(posedge clk_i) disable iff (rst_i)
      mem_we_o |=> !mem_we_o);
   // R2: PC steps by one across a fetch
   a_r2_pc_step: assert property (@(posedge clk_i) disable iff (rst_i)
      (step == S_FETCH) |=> pc_q == $past(pc_q) + 1'b1);
   // R5: load/store address is base plus index
   a_r5_ls_addr: assert property (@(posedge clk_i) disable iff (rst_i)
      (mem_we_o || (step == S_MEM)) |-> addr_o == ADDR_W'(a_q + b_q));
   // R6: flags change only after a compare
   a_r6_flags_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (step == S_EXEC && op != OP_CMP) |=> $stable(flg_q));

endmodule

// File: tb/test_cpu16_core.sv
module test_cpu16_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] addr;
   wire  [15:0] dbus;
   logic        rd, we;
   logic [15:0] mem [256];
   int          errors = 0;
   int          checks = 0;

   always #2 clk = ~clk;

   cpu16_core i_cpu16_core (
      .clk_i(clk), .rst_i(rst), .addr_o(addr), .data_io(dbus),
      .mem_rd_o(rd), .mem_we_o(we)
   );

   assign dbus = rd ? mem[addr[7:0]] : 16'hzzzz;
   always @(posedge clk) if (we) mem[addr[7:0]] <= dbus;

   typedef struct packed {
      logic [3:0]  kind;
      logic [15:0] a;
      logic [15:0] b;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{4'd0, 16'h1234, 16'h0F0F, 16'h2143},
      '{4'd0, 16'h7FFF, 16'h0001, 16'h8000},
      '{4'd1, 16'h0003, 16'h0005, 16'hFFFE},
      '{4'd1, 16'h8000, 16'h0001, 16'h7FFF},
      '{4'd2, 16'h0005, 16'h0005, 16'h0001},
      '{4'd3, 16'h0005, 16'h0005, 16'h0000},
      '{4'd4, 16'hFFFF, 16'h0001, 16'h0000},
      '{4'd4, 16'h0003, 16'hFFFE, 16'h0001},
      '{4'd5, 16'hFFFC, 16'hFFFC, 16'h0001},
      '{4'd6, 16'h8000, 16'h7FFF, 16'h0001},
      '{4'd7, 16'h0001, 16'h0002, 16'h0000},
      '{4'd6, 16'h0002, 16'h0001, 16'h0000},
      '{4'd8, 16'h0000, 16'h0000, 16'h0001},
      '{4'd9, 16'h0000, 16'h0000, 16'h0000},
      '{4'd7, 16'h7FFF, 16'h8000, 16'h0001},
      '{4'd5, 16'h0005, 16'h0004, 16'h0000}
   };

   function automatic logic [15:0] ei(input int op, input int r, input logic [7:0] k);
      return {4'(op), 4'(r), k};
   endfunction
   function automatic logic [15:0] er(input int op, input int d, input int s, input int t);
      return {4'(op), 4'(d), 4'(s), 4'(t)};
   endfunction

   localparam logic [15:0] HALT = 16'h76FF;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic start_prog();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
   endtask

   task automatic release_run(input int cyc);
      rst = 1'b0;
      repeat (cyc) @(negedge clk);
   endtask

   logic [15:0] t_addr [40];
   logic        t_rd [40];
   logic        t_we [40];
   logic [15:0] t_bus [40];

   initial begin
      // table walk: arithmetic (R3) and compare/branch (R6), undefined NOPs (R9)
      for (int v = 0; v < NV; v++) begin
         start_prog();
         mem[0] = ei(2, 2, 8'd64);
         mem[1] = ei(2, 4, 8'd1);
         mem[2] = er(4, 3, 2, 0);
         mem[3] = er(4, 5, 2, 4);
         mem[4] = ei(3, 4, 8'd1);
         if (VEC[v].kind < 4'd2) begin
            mem[5] = er(int'(VEC[v].kind), 6, 3, 5);
            mem[6] = er(15, 6, 3, 5);
            mem[7] = er(15, 6, 5, 3);
            mem[8] = er(12, 6, 0, 0);
         end else begin
            mem[5] = er(6, 0, 3, 5);
            mem[6] = ei(2, 6, 8'd1);
            mem[7] = {4'd7, 1'b0, 3'(VEC[v].kind - 4'd2), 8'h01};
            mem[8] = ei(2, 6, 8'd0);
         end
         mem[9]  = er(5, 6, 2, 4);
         mem[10] = HALT;
         mem[64] = VEC[v].a;
         mem[65] = VEC[v].b;
         release_run(80);
         if (VEC[v].kind < 4'd2) chk($sformatf("R3/R9 vec%0d", v), mem[66], VEC[v].exp);
         else                    chk($sformatf("R6 vec%0d", v), mem[66], VEC[v].exp);
         chk($sformatf("R5 load kept source vec%0d", v), mem[64], VEC[v].a);
      end

      // directed: reset, fetch timing, R0, sign extension, store bus
      start_prog();
      mem[0] = ei(2, 0, 8'd9);
      mem[1] = ei(2, 2, 8'd64);
      mem[2] = er(5, 0, 2, 0);
      mem[3] = ei(2, 6, 8'hFD);
      mem[4] = ei(2, 4, 8'd1);
      mem[5] = er(5, 6, 2, 4);
      mem[6] = HALT;
      mem[64] = 16'hAAAA;
      rst = 1'b0;
      for (int k = 0; k < 40; k++) begin
         if (k > 0) @(negedge clk);
         #1;
         t_addr[k] = addr; t_rd[k] = rd; t_we[k] = we; t_bus[k] = dbus;
      end
      chk("R1 first address", t_addr[0], 16'h0000);
      chk("R1 read strobe", {15'd0, t_rd[0]}, 16'h0001);
      chk("R1 write strobe low", {15'd0, t_we[0]}, 16'h0000);
      chk("R2 second fetch at 4", t_addr[4], 16'h0001);
      chk("R2 third fetch at 8", {t_addr[8][14:0], t_rd[8]}, 16'h0005);
      chk("R5 store strobe at 11", {15'd0, t_we[11]}, 16'h0001);
      chk("R5 store address", t_addr[11], 16'd64);
      chk("R8 zero register on bus", t_bus[11], 16'h0000);
      chk("R10 single write cycle", {15'd0, t_we[12]}, 16'h0000);
      chk("R10 no read while writing", {15'd0, t_rd[11]}, 16'h0000);
      chk("R2 fetch after store at 13", t_addr[13], 16'h0003);
      chk("R4 negative immediate on bus", t_bus[24], 16'hFFFD);
      chk("R4 store address", t_addr[24], 16'd65);
      chk("R8 write dropped", mem[64], 16'h0000);
      chk("R4 stored sext", mem[65], 16'hFFFD);

      // directed: call with value and reference parameters, return (R7)
      start_prog();
      mem[0]  = ei(2, 2, 8'd64);
      mem[1]  = ei(2, 3, 8'd65);
      mem[2]  = ei(2, 1, 8'd5);
      mem[3]  = ei(2, 4, 8'd2);
      mem[4]  = ei(8, 15, 8'd3);
      mem[5]  = er(5, 1, 2, 0);
      mem[6]  = er(5, 15, 2, 4);
      mem[7]  = HALT;
      mem[8]  = ei(3, 1, 8'd3);
      mem[9]  = er(5, 1, 3, 0);
      mem[10] = er(9, 0, 15, 0);
      release_run(90);
      chk("R7 value after return", mem[64], 16'd8);
      chk("R7 by-reference store", mem[65], 16'd8);
      chk("R7 link address", mem[66], 16'd5);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule